// File: doc/BRIEF.md
# Immediate Instruction Byte Decoder

This block accepts an instruction stream one byte per clock and turns each instruction that carries an immediate operand into a single decoded micro-operation. An instruction begins with an opcode byte. For some opcodes an addressing byte follows it. Then come the immediate bytes, least significant first: four bytes for most opcodes and one byte for the shift group.

Once the last byte of an instruction has been taken in, the decoder presents a one-cycle valid pulse. With that pulse it drives the following fields:
- the operation class;
- the destination register index;
- a flag saying whether the destination is the register itself or the memory word that register points to;
- the sub-operation code;
- the assembled immediate.

An opcode outside the supported set raises a one-cycle illegal pulse. So does an addressing byte that the block cannot serve. In both cases the decoder goes back to waiting for an opcode.

Bytes are taken only while the byte-valid input is high. Idle cycles may fall anywhere inside an instruction. The decoder handles register-direct and register-indirect destinations only. Displacements, index bytes and any other address arithmetic are handled by the stage that follows.

Top module: `imm_dec_top`

## Requirements
- R1: During and right after reset, `uop_valid` and `illegal` are 0 and every micro-operation field reads 0.
- R2: Immediate bytes are assembled little-endian: the first immediate byte lands in bits [7:0], the second in [15:8], and so on. So the bytes 0A 0B 0C 0D yield 0x0D0C0B0A.
- R3: Opcode 0x81 is followed by an addressing byte and four immediate bytes, and decodes to class ALU (code 1). In the addressing byte:
  - the destination register comes from bits [2:0];
  - the sub-operation comes from bits [5:3];
  - mode bits [7:6] = 11 select register-direct (`uop_mem`=0);
  - mode bits [7:6] = 00 select register-indirect (`uop_mem`=1).
- R4: The following opcodes take no addressing byte and four immediate bytes. Each decodes to class ALU with register 0, `uop_mem`=0 and a fixed sub-operation:
  - 0x0D gives sub-operation 1;
  - 0x25 gives sub-operation 4;
  - 0x2D gives sub-operation 5;
  - 0x35 gives sub-operation 6;
  - 0x3D gives sub-operation 7.
- R5: Opcodes 0xB8 to 0xBF take no addressing byte and four immediate bytes. Each decodes to class MOVE (code 3) with register = opcode − 0xB8, `uop_mem`=0 and sub-operation 0.
- R6: Opcode 0xC7 takes an addressing byte (decoded as in R3) and four immediate bytes, and decodes to class MOVE with sub-operation 0. If the addressing byte's bits [5:3] are not 0, the decoder pulses `illegal` in the next cycle, emits no micro-operation and returns to opcode fetch.
- R7: Opcode 0xC1 takes an addressing byte (decoded as in R3) followed by exactly one immediate byte. It decodes to class SHIFT (code 2), and the immediate is that byte zero-extended.
- R8: Opcode 0x68 takes no addressing byte and four immediate bytes. It decodes to class PUSH (code 4) with register 4 (the stack pointer), `uop_mem`=1 and sub-operation 0.
- R9: Any other opcode byte makes `illegal` pulse for exactly one cycle, in the cycle after the byte is taken. In that case `uop_valid` stays 0, the micro-operation fields keep their values and the next byte is treated as an opcode.
- R10: An addressing byte with mode bits [7:6] = 01 or 10 makes `illegal` pulse in the next cycle, emits no micro-operation and returns the decoder to opcode fetch.
- R11: `uop_valid` is high for exactly one cycle, in the cycle after the last byte of the instruction is taken. The fields hold their values until the next valid pulse.
- R12: A cycle with `byte_valid` low makes no progress: in the following cycle `uop_valid` and `illegal` are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_valid | input | 1 | `byte_data` holds an instruction byte this cycle |
| byte_data | input | 8 | Instruction byte |
| uop_valid | output | 1 | One-cycle pulse: the micro-operation fields are new |
| uop_class | output | 3 | Operation class: 0 none, 1 ALU, 2 SHIFT, 3 MOVE, 4 PUSH |
| uop_reg | output | 3 | Destination register index |
| uop_mem | output | 1 | 1: the destination is the memory word addressed by the register |
| uop_subop | output | 3 | Sub-operation code |
| uop_imm | output | 32 | Assembled immediate |
| illegal | output | 1 | One-cycle pulse: unsupported opcode or addressing byte |

## Verification
The hardest case to reach is an addressing byte that is rejected after its opcode has already been accepted. This happens with a non-zero sub-operation under 0xC7, or with a displacement mode under any of the three opcodes that take an addressing byte. After that rejection, the next byte must be treated as an opcode again. The bench sweeps all 256 addressing-byte values behind 0x81, 0xC1 and 0xC7 and follows every rejection with a fresh instruction, so a decoder stuck mid-instruction shows up as wrong fields. It also inserts idle cycles between bytes, so that stalls land in the addressing and immediate phases and not only at the opcode.

// File: rtl/imm_dec_pkg.sv
package imm_dec_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_W  = 3;
    localparam int SUB_W  = 3;

    localparam logic [REG_W-1:0] REG_ACC = 3'd0;
    localparam logic [REG_W-1:0] REG_SP  = 3'd4;

    typedef enum logic [2:0] {
        CLS_NONE  = 3'd0,
        CLS_ALU   = 3'd1,
        CLS_SHIFT = 3'd2,
        CLS_MOVE  = 3'd3,
        CLS_PUSH  = 3'd4
    } op_class_e;

    typedef enum logic [1:0] {
        ST_OP,
        ST_ADDR,
        ST_IMM
    } dec_state_e;

    typedef struct packed {
        logic             legal;
        logic             has_addr;
        op_class_e        cls;
        logic [REG_W-1:0] reg_idx;
        logic             to_mem;
        logic [SUB_W-1:0] subop;
    } op_info_t;

    function automatic op_info_t classify(input logic [BYTE_W-1:0] op);
        op_info_t r;
        r = '{legal: 1'b1, has_addr: 1'b0, cls: CLS_ALU,
              reg_idx: REG_ACC, to_mem: 1'b0, subop: '0};
        case (op)
            8'h81: r.has_addr = 1'b1;
            8'hC1: begin r.has_addr = 1'b1; r.cls = CLS_SHIFT; end
            8'hC7: begin r.has_addr = 1'b1; r.cls = CLS_MOVE;  end
            8'h0D: r.subop = 3'd1;
            8'h25: r.subop = 3'd4;
            8'h2D: r.subop = 3'd5;
            8'h35: r.subop = 3'd6;
            8'h3D: r.subop = 3'd7;
            8'h68: begin r.cls = CLS_PUSH; r.reg_idx = REG_SP; r.to_mem = 1'b1; end
            8'hB8, 8'hB9, 8'hBA, 8'hBB,
            8'hBC, 8'hBD, 8'hBE, 8'hBF: begin
                r.cls     = CLS_MOVE;
                r.reg_idx = op[REG_W-1:0];
            end
            default: begin r.legal = 1'b0; r.cls = CLS_NONE; end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/imm_dec_opcode.sv
module imm_dec_opcode
    import imm_dec_pkg::*;
(
    input  logic [BYTE_W-1:0] opcode,
    output op_info_t          info
);
    always_comb info = classify(opcode);
endmodule

// File: rtl/imm_dec_addr.sv
module imm_dec_addr
    import imm_dec_pkg::*;
(
    input  logic [BYTE_W-1:0] addr_byte,
    input  logic              copy_only,
    output logic [REG_W-1:0]  reg_idx,
    output logic              to_mem,
    output logic [SUB_W-1:0]  subop,
    output logic              bad
);
    logic [1:0] mode;

    always_comb begin
        mode    = addr_byte[7:6];
        reg_idx = addr_byte[2:0];
        subop   = addr_byte[5:3];
        to_mem  = (mode == 2'b00);
        bad     = (mode == 2'b01) || (mode == 2'b10) || (copy_only && (subop != '0));
    end
endmodule

// File: rtl/imm_dec_imm.sv
module imm_dec_imm
    import imm_dec_pkg::*;
#(
    parameter int IMM_BYTES = 4,
    localparam int IMM_W = IMM_BYTES * BYTE_W,
    localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              wr,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] din,
    output logic [IMM_W-1:0]  acc_next
);
    logic [IMM_W-1:0] acc;

    for (genvar k = 0; k < IMM_BYTES; k++) begin : g_lane
        logic hit;
        assign hit = wr && (idx == IDX_W'(k));
        assign acc_next[k*BYTE_W +: BYTE_W] = hit ? din : acc[k*BYTE_W +: BYTE_W];
    end

    always_ff @(posedge clk) begin
        if (rst || clr) acc <= '0;
        else            acc <= acc_next;
    end
endmodule

// File: rtl/imm_dec_top.sv
module imm_dec_top
    import imm_dec_pkg::*;
#(
    parameter int IMM_BYTES   = 4,
    parameter int SHIFT_BYTES = 1,
    localparam int IMM_W = IMM_BYTES * BYTE_W,
    localparam int IDX_W = (IMM_BYTES > 1) ? $clog2(IMM_BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              byte_valid,
    input  logic [BYTE_W-1:0] byte_data,
    output logic              uop_valid,
    output logic [2:0]        uop_class,
    output logic [REG_W-1:0]  uop_reg,
    output logic              uop_mem,
    output logic [SUB_W-1:0]  uop_subop,
    output logic [IMM_W-1:0]  uop_imm,
    output logic              illegal
);
    localparam logic [IDX_W-1:0] LAST_FULL  = IDX_W'(IMM_BYTES - 1);
    localparam logic [IDX_W-1:0] LAST_SHIFT = IDX_W'(SHIFT_BYTES - 1);

    dec_state_e       state;
    op_class_e        pend_cls;
    logic [REG_W-1:0] pend_reg;
    logic             pend_mem;
    logic [SUB_W-1:0] pend_sub;
    logic [IDX_W-1:0] cnt;
    logic [IDX_W-1:0] last_idx;

    op_class_e        out_cls;
    logic             valid_q;
    logic             illegal_q;

    op_info_t         info;
    logic [REG_W-1:0] a_reg;
    logic             a_mem;
    logic [SUB_W-1:0] a_sub;
    logic             a_bad;
    logic [IMM_W-1:0] imm_next;

    logic take_op, take_addr, take_imm;

    assign take_op   = byte_valid && (state == ST_OP);
    assign take_addr = byte_valid && (state == ST_ADDR);
    assign take_imm  = byte_valid && (state == ST_IMM);

    imm_dec_opcode u_opcode (
        .opcode (byte_data),
        .info   (info)
    );

    imm_dec_addr u_addr (
        .addr_byte (byte_data),
        .copy_only (pend_cls == CLS_MOVE),
        .reg_idx   (a_reg),
        .to_mem    (a_mem),
        .subop     (a_sub),
        .bad       (a_bad)
    );

    imm_dec_imm #(.IMM_BYTES(IMM_BYTES)) u_imm (
        .clk      (clk),
        .rst      (rst),
        .clr      (take_op),
        .wr       (take_imm),
        .idx      (cnt),
        .din      (byte_data),
        .acc_next (imm_next)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_OP;
            pend_cls  <= CLS_NONE;
            pend_reg  <= '0;
            pend_mem  <= 1'b0;
            pend_sub  <= '0;
            cnt       <= '0;
            last_idx  <= '0;
            out_cls   <= CLS_NONE;
            uop_reg   <= '0;
            uop_mem   <= 1'b0;
            uop_subop <= '0;
            uop_imm   <= '0;
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            valid_q   <= 1'b0;
            illegal_q <= 1'b0;
            if (take_op) begin
                if (!info.legal) begin
                    illegal_q <= 1'b1;
                end else begin
                    pend_cls <= info.cls;
                    pend_reg <= info.reg_idx;
                    pend_mem <= info.to_mem;
                    pend_sub <= info.subop;
                    cnt      <= '0;
                    last_idx <= LAST_FULL;
                    state    <= info.has_addr ? ST_ADDR : ST_IMM;
                end
            end else if (take_addr) begin
                if (a_bad) begin
                    illegal_q <= 1'b1;
                    state     <= ST_OP;
                end else begin
                    pend_reg <= a_reg;
                    pend_mem <= a_mem;
                    pend_sub <= a_sub;
                    last_idx <= (pend_cls == CLS_SHIFT) ? LAST_SHIFT : LAST_FULL;
                    state    <= ST_IMM;
                end
            end else if (take_imm) begin
                cnt <= cnt + 1'b1;
                if (cnt == last_idx) begin
                    valid_q   <= 1'b1;
                    out_cls   <= pend_cls;
                    uop_reg   <= pend_reg;
                    uop_mem   <= pend_mem;
                    uop_subop <= pend_sub;
                    uop_imm   <= imm_next;
                    state     <= ST_OP;
                end
            end
        end
    end

    assign uop_valid = valid_q;
    assign illegal   = illegal_q;
    assign uop_class = out_cls;

endmodule

// File: rtl/imm_dec_checker.sv
module imm_dec_checker #(
    parameter int IMM_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             byte_valid,
    input logic             uop_valid,
    input logic [2:0]       uop_class,
    input logic [2:0]       uop_reg,
    input logic             uop_mem,
    input logic [2:0]       uop_subop,
    input logic [IMM_W-1:0] uop_imm,
    input logic             illegal
);
    AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
        !(uop_valid && illegal)); // R9

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        uop_valid |=> !uop_valid); // R11

    AST_FIELDS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !uop_valid |-> ($stable(uop_imm) && $stable(uop_class) && $stable(uop_reg)
                        && $stable(uop_mem) && $stable(uop_subop))); // R11

    AST_COPY_SUBOP: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_class == 3'd3) |-> (uop_subop == 3'd0)); // R6

    AST_SHIFT_NARROW: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_class == 3'd2) |-> ((uop_imm >> 8) == '0)); // R7

    AST_PUSH_DEST: assert property (@(posedge clk) disable iff (rst)
        (uop_valid && uop_class == 3'd4) |-> (uop_reg == 3'd4 && uop_mem)); // R8

    AST_NO_STALL_PROGRESS: assert property (@(posedge clk) disable iff (rst)
        !byte_valid |=> (!uop_valid && !illegal)); // R12
endmodule

bind imm_dec_top imm_dec_checker #(.IMM_W(IMM_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .byte_valid (byte_valid),
    .uop_valid  (uop_valid),
    .uop_class  (uop_class),
    .uop_reg    (uop_reg),
    .uop_mem    (uop_mem),
    .uop_subop  (uop_subop),
    .uop_imm    (uop_imm),
    .illegal    (illegal)
);

// File: tb/imm_dec_top_bench.sv
`timescale 1ns/1ps
module imm_dec_top_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        byte_valid = 1'b0;
    logic [7:0]  byte_data = 8'h00;
    logic        uop_valid;
    logic [2:0]  uop_class;
    logic [2:0]  uop_reg;
    logic        uop_mem;
    logic [2:0]  uop_subop;
    logic [31:0] uop_imm;
    logic        illegal;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    logic [2:0]  e_cls = 3'd0;
    logic [2:0]  e_reg = 3'd0;
    logic        e_mem = 1'b0;
    logic [2:0]  e_sub = 3'd0;
    logic [31:0] e_imm = 32'd0;

    always #2 clk = ~clk;

    imm_dec_top u_imm_dec_top (
        .clk(clk), .rst(rst), .byte_valid(byte_valid), .byte_data(byte_data),
        .uop_valid(uop_valid), .uop_class(uop_class), .uop_reg(uop_reg),
        .uop_mem(uop_mem), .uop_subop(uop_subop), .uop_imm(uop_imm), .illegal(illegal)
    );

    task automatic ceq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
    endtask

    task automatic idle(input int g);
        for (int i = 0; i < g; i++) begin
            @(negedge clk);
            byte_valid = 1'b0;
            byte_data  = 8'hA5;
            if (i > 0) begin
                ceq("R12 no valid while stalled", {31'd0, uop_valid}, 32'd0);
                ceq("R12 no illegal while stalled", {31'd0, illegal}, 32'd0);
            end
        end
    endtask

    task automatic fields_unchanged(input string tag);
        ceq({tag, " class kept"}, {29'd0, uop_class}, {29'd0, e_cls});
        ceq({tag, " reg kept"},   {29'd0, uop_reg},   {29'd0, e_reg});
        ceq({tag, " mem kept"},   {31'd0, uop_mem},   {31'd0, e_mem});
        ceq({tag, " subop kept"}, {29'd0, uop_subop}, {29'd0, e_sub});
        ceq({tag, " imm kept"},   uop_imm,            e_imm);
    endtask

    task automatic expect_illegal(input string tag);
        @(negedge clk);
        byte_valid = 1'b0;
        ceq({tag, " illegal pulse"}, {31'd0, illegal}, 32'd1);
        ceq({tag, " no valid"}, {31'd0, uop_valid}, 32'd0);
        fields_unchanged(tag);
        @(negedge clk);
        ceq({tag, " illegal one cycle"}, {31'd0, illegal}, 32'd0);
    endtask

    task automatic run_instr(input logic [7:0] op, input logic [7:0] am,
                             input logic [31:0] imm, input int gap);
        bit          has_am, legal;
        int          nb;
        logic [2:0]  x_cls, x_reg, x_sub;
        logic        x_mem;
        string       tag;
        has_am = (op == 8'h81) || (op == 8'hC1) || (op == 8'hC7);
        legal  = has_am || (op == 8'h0D) || (op == 8'h25) || (op == 8'h2D) ||
                 (op == 8'h35) || (op == 8'h3D) || (op == 8'h68) ||
                 (op >= 8'hB8 && op <= 8'hBF);
        send(op);
        if (!legal) begin
            expect_illegal("R9 unknown opcode");
            return;
        end
        x_sub = 3'd0; x_mem = 1'b0; x_reg = 3'd0; nb = 4;
        if (has_am) begin
            idle(gap);
            send(am);
            if (am[7:6] == 2'b01 || am[7:6] == 2'b10) begin
                expect_illegal("R10 displacement mode");
                return;
            end
            if (op == 8'hC7 && am[5:3] != 3'd0) begin
                expect_illegal("R6 copy with nonzero subop");
                return;
            end
            x_reg = am[2:0];
            x_mem = (am[7:6] == 2'b00);
            x_sub = (op == 8'hC7) ? 3'd0 : am[5:3];
        end
        if (op == 8'h81)                     begin x_cls = 3'd1; tag = "R3 group alu"; end
        else if (op == 8'hC1)                begin x_cls = 3'd2; tag = "R7 shift"; nb = 1; end
        else if (op == 8'hC7)                begin x_cls = 3'd3; tag = "R6 copy"; end
        else if (op == 8'h68)                begin x_cls = 3'd4; tag = "R8 push"; x_reg = 3'd4; x_mem = 1'b1; end
        else if (op >= 8'hB8)                begin x_cls = 3'd3; tag = "R5 move reg"; x_reg = 3'(op - 8'hB8); end
        else begin
            x_cls = 3'd1; tag = "R4 accumulator alu";
            case (op)
                8'h0D: x_sub = 3'd1;
                8'h25: x_sub = 3'd4;
                8'h2D: x_sub = 3'd5;
                8'h35: x_sub = 3'd6;
                default: x_sub = 3'd7;
            endcase
        end
        for (int k = 0; k < nb; k++) begin
            idle(gap);
            send(8'((imm >> (8 * k)) & 32'hFF));
        end
        @(negedge clk);
        byte_valid = 1'b0;
        e_cls = x_cls; e_reg = x_reg; e_mem = x_mem; e_sub = x_sub;
        e_imm = (nb == 1) ? (imm & 32'hFF) : imm;
        ceq({tag, " R11 valid pulse"}, {31'd0, uop_valid}, 32'd1);
        ceq({tag, " R9 no illegal"}, {31'd0, illegal}, 32'd0);
        ceq({tag, " class"}, {29'd0, uop_class}, {29'd0, e_cls});
        ceq({tag, " reg"},   {29'd0, uop_reg},   {29'd0, e_reg});
        ceq({tag, " mem"},   {31'd0, uop_mem},   {31'd0, e_mem});
        ceq({tag, " subop"}, {29'd0, uop_subop}, {29'd0, e_sub});
        ceq({tag, " R2 imm"}, uop_imm, e_imm);
        @(negedge clk);
        ceq("R11 valid lasts one cycle", {31'd0, uop_valid}, 32'd0);
        fields_unchanged("R11 hold");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        ceq("R1 valid low in reset", {31'd0, uop_valid}, 32'd0);
        ceq("R1 illegal low in reset", {31'd0, illegal}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        ceq("R1 valid low after reset", {31'd0, uop_valid}, 32'd0);
        fields_unchanged("R1 reset");

        // R2: little-endian example 0A 0B 0C 0D
        run_instr(8'h81, 8'hC3, 32'h0D0C0B0A, 0);
        ceq("R2 example value", uop_imm, 32'h0D0C0B0A);

        // Every opcode, with mode 00 or 11 addressing bytes and varied stalls
        for (int op = 0; op < 256; op++) begin
            logic [7:0] o, am;
            o  = 8'(op);
            am = {o[0] ? 2'b11 : 2'b00, o[6:4], o[3:1]};
            run_instr(o, am, {~o, o ^ 8'h5A, 8'h3C, o}, op % 3);
        end

        // Every addressing byte behind each opcode that takes one
        for (int m = 0; m < 256; m++) begin
            logic [7:0] a;
            a = 8'(m);
            run_instr(8'h81, a, {a, 8'hF0, ~a, 8'h11}, 0);
            run_instr(8'hC1, a, {8'hEE, 8'hDD, 8'hCC, a ^ 8'h96}, m % 2);
            run_instr(8'hC7, a, {8'h12, a, 8'h34, ~a}, 0);
        end

        // Push with a small value
        run_instr(8'h68, 8'h00, 32'h000000AF, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule